// File: doc/BRIEF.md
# Oscillator Trim Controller with Frequency Error Measurement

This block measures a local oscillator against a slower reference pulse and nudges a trim code so that the oscillator drifts toward its target. Reference pulses enter on `sync_in` and pass through a power-of-two prescaler. Each prescaled event reloads a 16-bit error counter. The counter first counts down once per clock. When it reaches zero it turns around and counts up until the next event. The counter value and its direction at the moment of an event therefore give the size and sign of the frequency error over the last reference period.

At each event the block grades the captured error against a programmable limit. It then leaves the trim code alone, steps it by one, or steps it by two. The step direction follows the captured counting direction. Six sticky flags report the outcome: in-limit, warning, expected-reference, trim saturation, missed reference and early reference. The three error kinds also show as one combined error flag. Each of the four reported groups drives an interrupt through its own enable. A clear strobe drops the matching flags on the next clock.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset, `trim_val` is 32, `cap_val` is 0, `cap_dir` is 0, and every flag and interrupt output is 0.
- R2: With `sync_div` = N, a prescaled event occurs on every 2^N-th rising edge of `sync_in` (N = 0 gives one event per edge). Edges that do not complete a group leave `cap_val` and `trim_val` unchanged.
- R3: The first prescaled event after reset only loads the counter: it sets no flag and leaves `trim_val` and `cap_val` unchanged.
- R4: With reload value R and P clock cycles between two consecutive prescaled events, the second event sets `cap_dir` and `cap_val` as follows. If P-1 ≤ R, then `cap_dir` = 1 (counting down) and `cap_val` = R-(P-1). Otherwise `cap_dir` = 0 (counting up) and `cap_val` = (P-1)-R.
- R5: If the graded error is below `err_limit`, `ok_flag` is set and `trim_val` is unchanged.
- R6: If the graded error is at least `err_limit` and below 3×`err_limit`, `warn_flag` is set and `trim_val` moves by 1. It rises when `cap_dir` = 1 and falls when `cap_dir` = 0.
- R7: If the graded error is at least 3×`err_limit`, `warn_flag` is set and `trim_val` moves by 2, in the same direction rule as R6.
- R8: When the down count reaches zero before the next event, `esync_flag` is set.
- R9: When the up count reaches 3×`err_limit` with no event, `miss_flag` and `err_flag` are set. The next event captures as usual but does not change `trim_val`.
- R10: An event that arrives while counting down with the counter above 3×`err_limit` sets `sync_err_flag` and `err_flag`, and leaves `trim_val` unchanged.
- R11: A step that would take `trim_val` above 63 or below 0 saturates it at 63 or 0 and sets `trim_err_flag` and `err_flag`.
- R12: Flags stay set until their clear strobe. They read 0 one clock after the strobe. `err_clr` clears the trim, miss and early flags together. Each interrupt output is its flag (for errors, `err_flag`) ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Reference pulse, synchronous to clk |
| reload_val | input | 16 | Counter load value per event |
| err_limit | input | 8 | Error tolerance |
| sync_div | input | 3 | Prescaler exponent |
| ok_ie | input | 1 | In-limit interrupt enable |
| warn_ie | input | 1 | Warning interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| esync_ie | input | 1 | Expected-reference interrupt enable |
| ok_clr | input | 1 | Clear strobe for ok_flag |
| warn_clr | input | 1 | Clear strobe for warn_flag |
| err_clr | input | 1 | Clear strobe for all error flags |
| esync_clr | input | 1 | Clear strobe for esync_flag |
| trim_val | output | 6 | Current trim code |
| cap_val | output | 16 | Captured counter value |
| cap_dir | output | 1 | Captured direction, 1 = down (slow) |
| ok_flag | output | 1 | Error within limit |
| warn_flag | output | 1 | Trim step taken |
| err_flag | output | 1 | OR of the three error flags |
| esync_flag | output | 1 | Down count reached zero |
| trim_err_flag | output | 1 | Trim saturated |
| miss_flag | output | 1 | Reference missed |
| sync_err_flag | output | 1 | Reference arrived too early |
| ok_irq | output | 1 | In-limit interrupt |
| warn_irq | output | 1 | Warning interrupt |
| err_irq | output | 1 | Error interrupt |
| esync_irq | output | 1 | Expected-reference interrupt |

## Verification
The bench uses the default widths with a reload of 100 and a limit of 4, so the band edges fall at errors of 4 and 12. Reference periods of tens of cycles can then land on each grading band, on the exact 3×limit boundary, and on both early and missed references. A prescaler setting of 2 shows grouping of four edges. Sixteen to thirty-two coarse steps drive the 6-bit trim into both saturation ends within a few thousand cycles.

// File: rtl/trim_pkg.sv
package trim_pkg;
    typedef enum logic [1:0] {
        GR_NONE   = 2'd0,
        GR_OK     = 2'd1,
        GR_FINE   = 2'd2,
        GR_COARSE = 2'd3
    } grade_e;
endpackage

// File: rtl/sync_prescaler.sv
module sync_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [DIV_W-1:0] div_sel,
    output logic             evt_o
);
    localparam int PCNT_W = (1 << DIV_W) - 1;
    localparam logic [PCNT_W-1:0] ONES = '1;

    typedef struct packed {
        logic              prev;
        logic [PCNT_W-1:0] cnt;
        logic              evt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PCNT_W-1:0] term;
    logic edge_seen;

    always_comb begin
        term      = ONES >> (PCNT_W - int'(div_sel));
        edge_seen = sync_in & ~st_q.prev;
        st_d      = st_q;
        st_d.prev = sync_in;
        st_d.evt  = 1'b0;
        if (edge_seen) begin
            if (st_q.cnt >= term) begin
                st_d.cnt = '0;
                st_d.evt = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = st_q.evt;
endmodule

// File: rtl/err_counter.sv
module err_counter
    import trim_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [LIM_W-1:0] lim_i,
    input  logic [LIM_W+1:0] lim3_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             cap_dir_o,
    output grade_e           grade_o,
    output logic             esync_o,
    output logic             miss_o,
    output logic             serr_o
);
    localparam int PAD = CNT_W - LIM_W - 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             armed;
        logic             missed;
        logic [CNT_W-1:0] cap;
        logic             cap_dir;
        grade_e           grade;
        logic             esync;
        logic             miss;
        logic             serr;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [CNT_W-1:0] lim_x, lim3_x;

    always_comb begin
        lim_x      = {{(PAD + 2){1'b0}}, lim_i};
        lim3_x     = {{PAD{1'b0}}, lim3_i};
        st_d       = st_q;
        st_d.grade = GR_NONE;
        st_d.esync = 1'b0;
        st_d.miss  = 1'b0;
        st_d.serr  = 1'b0;
        if (evt_i) begin
            st_d.cnt    = reload_i;
            st_d.down   = 1'b1;
            st_d.armed  = 1'b1;
            st_d.missed = 1'b0;
            if (st_q.armed) begin
                st_d.cap     = st_q.cnt;
                st_d.cap_dir = st_q.down;
                if (st_q.down && (st_q.cnt > lim3_x)) begin
                    st_d.serr = 1'b1;
                end else if (!st_q.missed) begin
                    if (st_q.cnt < lim_x)       st_d.grade = GR_OK;
                    else if (st_q.cnt < lim3_x) st_d.grade = GR_FINE;
                    else                        st_d.grade = GR_COARSE;
                end
            end
        end else if (st_q.down) begin
            if (st_q.cnt == '0) begin
                st_d.down  = 1'b0;
                st_d.cnt   = {{(CNT_W-1){1'b0}}, 1'b1};
                st_d.esync = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.armed && !st_q.missed && (st_q.cnt >= lim3_x)) begin
                st_d.miss   = 1'b1;
                st_d.missed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o     = st_q.cap;
    assign cap_dir_o = st_q.cap_dir;
    assign grade_o   = st_q.grade;
    assign esync_o   = st_q.esync;
    assign miss_o    = st_q.miss;
    assign serr_o    = st_q.serr;
endmodule

// File: rtl/trim_adjust.sv
module trim_adjust
    import trim_pkg::*;
#(
    parameter int TRIM_W   = 6,
    parameter int TRIM_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  grade_e            grade_i,
    input  logic              up_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic              sat_o
);
    localparam logic [TRIM_W:0]   TRIM_MAX = (TRIM_W+1)'((1 << TRIM_W) - 1);
    localparam logic [TRIM_W-1:0] TRIM_INIT = TRIM_W'(TRIM_RST);

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
        logic              sat;
    } trim_t;

    trim_t st_d, st_q;
    logic [TRIM_W:0] step, sum;

    always_comb begin
        case (grade_i)
            GR_FINE:   step = (TRIM_W+1)'(1);
            GR_COARSE: step = (TRIM_W+1)'(2);
            default:   step = '0;
        endcase
        sum      = {1'b0, st_q.trim} + step;
        st_d     = st_q;
        st_d.sat = 1'b0;
        if (step != '0) begin
            if (up_i) begin
                if (sum > TRIM_MAX) begin
                    st_d.trim = TRIM_MAX[TRIM_W-1:0];
                    st_d.sat  = 1'b1;
                end else begin
                    st_d.trim = sum[TRIM_W-1:0];
                end
            end else begin
                if ({1'b0, st_q.trim} < step) begin
                    st_d.trim = '0;
                    st_d.sat  = 1'b1;
                end else begin
                    st_d.trim = st_q.trim - step[TRIM_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{trim: TRIM_INIT, sat: 1'b0};
        else        st_q <= st_d;
    end

    assign trim_o = st_q.trim;
    assign sat_o  = st_q.sat;
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
    import trim_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int LIM_W    = 8,
    parameter int DIV_W    = 3,
    parameter int TRIM_W   = 6,
    parameter int TRIM_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [LIM_W-1:0]  err_limit,
    input  logic [DIV_W-1:0]  sync_div,
    input  logic              ok_ie,
    input  logic              warn_ie,
    input  logic              err_ie,
    input  logic              esync_ie,
    input  logic              ok_clr,
    input  logic              warn_clr,
    input  logic              err_clr,
    input  logic              esync_clr,
    output logic [TRIM_W-1:0] trim_val,
    output logic [CNT_W-1:0]  cap_val,
    output logic              cap_dir,
    output logic              ok_flag,
    output logic              warn_flag,
    output logic              err_flag,
    output logic              esync_flag,
    output logic              trim_err_flag,
    output logic              miss_flag,
    output logic              sync_err_flag,
    output logic              ok_irq,
    output logic              warn_irq,
    output logic              err_irq,
    output logic              esync_irq
);
    typedef struct packed {
        logic ok;
        logic warn;
        logic esync;
        logic tovf;
        logic miss;
        logic serr;
    } flag_t;

    flag_t fl_d, fl_q;
    logic sync_evt;
    logic [LIM_W+1:0] lim_x3;
    grade_e grade;
    logic esync_p, miss_p, serr_p, sat_p;

    assign lim_x3 = {1'b0, err_limit, 1'b0} + {2'b00, err_limit};

    sync_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .div_sel (sync_div),
        .evt_o   (sync_evt)
    );

    err_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (sync_evt),
        .reload_i  (reload_val),
        .lim_i     (err_limit),
        .lim3_i    (lim_x3),
        .cap_o     (cap_val),
        .cap_dir_o (cap_dir),
        .grade_o   (grade),
        .esync_o   (esync_p),
        .miss_o    (miss_p),
        .serr_o    (serr_p)
    );

    trim_adjust #(.TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_trim (
        .clk     (clk),
        .rst_n   (rst_n),
        .grade_i (grade),
        .up_i    (cap_dir),
        .trim_o  (trim_val),
        .sat_o   (sat_p)
    );

    always_comb begin
        fl_d = fl_q;
        if (ok_clr)    fl_d.ok    = 1'b0;
        if (warn_clr)  fl_d.warn  = 1'b0;
        if (esync_clr) fl_d.esync = 1'b0;
        if (err_clr) begin
            fl_d.tovf = 1'b0;
            fl_d.miss = 1'b0;
            fl_d.serr = 1'b0;
        end
        if (grade == GR_OK)                          fl_d.ok    = 1'b1;
        if (grade == GR_FINE || grade == GR_COARSE)  fl_d.warn  = 1'b1;
        if (esync_p)                                 fl_d.esync = 1'b1;
        if (sat_p)                                   fl_d.tovf  = 1'b1;
        if (miss_p)                                  fl_d.miss  = 1'b1;
        if (serr_p)                                  fl_d.serr  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign ok_flag       = fl_q.ok;
    assign warn_flag     = fl_q.warn;
    assign esync_flag    = fl_q.esync;
    assign trim_err_flag = fl_q.tovf;
    assign miss_flag     = fl_q.miss;
    assign sync_err_flag = fl_q.serr;
    assign err_flag      = fl_q.tovf | fl_q.miss | fl_q.serr;
    assign ok_irq        = fl_q.ok & ok_ie;
    assign warn_irq      = fl_q.warn & warn_ie;
    assign err_irq       = err_flag & err_ie;
    assign esync_irq     = fl_q.esync & esync_ie;
endmodule

// File: rtl/trim_checker.sv
module trim_checker #(
    parameter int TRIM_W = 6,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TRIM_W-1:0] trim,
    input logic              tovf,
    input logic              ok_flag,
    input logic              ok_clr,
    input logic              warn_flag,
    input logic              evt,
    input logic [CNT_W-1:0]  cap
);
    // R7
    trim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(trim) - int'($past(trim)) <= 2) && (int'(trim) - int'($past(trim)) >= -2)));

    // R11
    trim_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tovf) |-> (trim == '0 || trim == '1));

    // R12
    ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_flag && !ok_clr) |=> ok_flag);

    // R6
    trim_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim != $past(trim)) |-> warn_flag);

    // R2
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(evt) |-> $stable(cap));
endmodule

bind osc_trim_ctrl trim_checker #(.TRIM_W(TRIM_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trim      (trim_val),
    .tovf      (trim_err_flag),
    .ok_flag   (ok_flag),
    .ok_clr    (ok_clr),
    .warn_flag (warn_flag),
    .evt       (sync_evt),
    .cap       (cap_val)
);

// File: tb/tb_osc_trim_ctrl.sv
module tb_osc_trim_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b0;
    logic [15:0] reload_val = 16'd100;
    logic [7:0]  err_limit = 8'd4;
    logic [2:0]  sync_div = 3'd0;
    logic        ok_ie = 0, warn_ie = 0, err_ie = 0, esync_ie = 0;
    logic        ok_clr = 0, warn_clr = 0, err_clr = 0, esync_clr = 0;
    logic [5:0]  trim_val;
    logic [15:0] cap_val;
    logic        cap_dir, ok_flag, warn_flag, err_flag, esync_flag;
    logic        trim_err_flag, miss_flag, sync_err_flag;
    logic        ok_irq, warn_irq, err_irq, esync_irq;

    int checks = 0;
    int errors = 0;
    int waited = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    osc_trim_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .reload_val(reload_val),
        .err_limit(err_limit), .sync_div(sync_div),
        .ok_ie(ok_ie), .warn_ie(warn_ie), .err_ie(err_ie), .esync_ie(esync_ie),
        .ok_clr(ok_clr), .warn_clr(warn_clr), .err_clr(err_clr), .esync_clr(esync_clr),
        .trim_val(trim_val), .cap_val(cap_val), .cap_dir(cap_dir),
        .ok_flag(ok_flag), .warn_flag(warn_flag), .err_flag(err_flag),
        .esync_flag(esync_flag), .trim_err_flag(trim_err_flag),
        .miss_flag(miss_flag), .sync_err_flag(sync_err_flag),
        .ok_irq(ok_irq), .warn_irq(warn_irq), .err_irq(err_irq), .esync_irq(esync_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Waits out the rest of a period of g cycles since the last pulse, then pulses.
    task automatic period(input int g);
        repeat (g - 1 - waited) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        waited = 0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
        waited += 6;
    endtask

    task automatic clear_all();
        ok_clr = 1; warn_clr = 1; err_clr = 1; esync_clr = 1;
        @(negedge clk);
        ok_clr = 0; warn_clr = 0; err_clr = 0; esync_clr = 0;
        waited += 1;
    endtask

    task automatic t_reset();
        chk("R1 trim", trim_val, 32);
        chk("R1 cap", cap_val, 0);
        chk("R1 dir", cap_dir, 0);
        chk("R1 flags", {ok_flag, warn_flag, err_flag, esync_flag, trim_err_flag,
                         miss_flag, sync_err_flag}, 0);
        chk("R1 irqs", {ok_irq, warn_irq, err_irq, esync_irq}, 0);
    endtask

    task automatic t_first();
        period(1 + waited);
        settle();
        chk("R3 trim", trim_val, 32);
        chk("R3 cap", cap_val, 0);
        chk("R3 flags", {ok_flag, warn_flag, err_flag}, 0);
    endtask

    task automatic t_ok();
        period(101);
        settle();
        chk("R4 cap exact", cap_val, 0);
        chk("R4 dir exact", cap_dir, 1);
        chk("R5 ok", ok_flag, 1);
        chk("R5 trim", trim_val, 32);
        chk("R5 warn", warn_flag, 0);
        ok_ie = 1;
        @(negedge clk); waited += 1;
        chk("R12 ok irq", ok_irq, 1);
        ok_ie = 0;
        settle();
        chk("R12 ok sticky", ok_flag, 1);
        clear_all();
        chk("R12 ok cleared", ok_flag, 0);
    endtask

    task automatic t_fast();
        esync_ie = 1;
        period(106);
        settle();
        chk("R4 cap fast", cap_val, 5);
        chk("R4 dir fast", cap_dir, 0);
        chk("R6 trim down", trim_val, 31);
        chk("R6 warn", warn_flag, 1);
        chk("R8 esync", esync_flag, 1);
        chk("R12 esync irq", esync_irq, 1);
        esync_ie = 0;
        clear_all();
    endtask

    task automatic t_slow_fine();
        period(91);
        settle();
        chk("R4 cap slow", cap_val, 10);
        chk("R4 dir slow", cap_dir, 1);
        chk("R6 trim up", trim_val, 32);
        chk("R8 no esync", esync_flag, 0);
        clear_all();
    endtask

    task automatic t_coarse();
        period(89);
        settle();
        chk("R7 cap edge", cap_val, 12);
        chk("R7 trim up2", trim_val, 34);
        chk("R7 warn", warn_flag, 1);
        period(113);
        settle();
        chk("R7 cap up edge", cap_val, 12);
        chk("R7 dir up", cap_dir, 0);
        chk("R7 trim down2", trim_val, 32);
        chk("R9 no miss at edge", miss_flag, 0);
        clear_all();
    endtask

    task automatic t_serr();
        period(81);
        settle();
        chk("R10 cap", cap_val, 20);
        chk("R10 flag", sync_err_flag, 1);
        chk("R10 err", err_flag, 1);
        chk("R10 trim", trim_val, 32);
        chk("R10 warn", warn_flag, 0);
        clear_all();
        chk("R12 err cleared", err_flag, 0);
    endtask

    task automatic t_miss();
        period(120);
        settle();
        chk("R9 miss", miss_flag, 1);
        chk("R9 err", err_flag, 1);
        chk("R9 cap", cap_val, 19);
        chk("R9 trim", trim_val, 32);
        chk("R9 warn", warn_flag, 0);
        clear_all();
    endtask

    task automatic t_div();
        int cap_before;
        sync_div = 3'd2;
        for (int i = 0; i < 4; i++) period(26);
        settle();
        clear_all();
        cap_before = cap_val;
        for (int i = 0; i < 3; i++) period(26);
        settle();
        chk("R2 partial cap", cap_val, cap_before);
        chk("R2 partial trim", trim_val, 32);
        period(26);
        settle();
        chk("R2 grouped cap", cap_val, 3);
        chk("R2 grouped dir", cap_dir, 0);
        chk("R2 grouped ok", ok_flag, 1);
        sync_div = 3'd0;
        clear_all();
    endtask

    task automatic t_sat();
        for (int i = 0; i < 20; i++) period(89);
        settle();
        chk("R11 trim max", trim_val, 63);
        chk("R11 ovf", trim_err_flag, 1);
        chk("R11 err", err_flag, 1);
        err_ie = 1;
        @(negedge clk); waited += 1;
        chk("R12 err irq", err_irq, 1);
        clear_all();
        chk("R12 ovf cleared", trim_err_flag, 0);
        chk("R12 err irq off", err_irq, 0);
        for (int i = 0; i < 35; i++) period(113);
        settle();
        chk("R11 trim min", trim_val, 0);
        chk("R11 ovf low", trim_err_flag, 1);
        err_ie = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first();
        t_ok();
        t_fast();
        t_slow_fine();
        t_coarse();
        t_serr();
        t_miss();
        t_div();
        t_sat();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule